// File: doc/BRIEF.md
# Torus Node Router with Dateline Virtual Channels

This block is the routing and channel-allocation stage of one node in a three-dimensional torus. Seven input ports (six neighbour links plus local injection) each present a decoded packet header: destination coordinates, a traffic class (request or response), the virtual-channel level it arrived on, and the packet length in 16-bit phits. The router picks an output port by dimension-order routing, taking the shorter way round each ring. It then picks one of four virtual channels on that link and grants the input once the downstream buffer has room for the whole packet.

After a grant, the input streams its phits. The router forwards each one to the chosen output a cycle later, tagged with the virtual channel. The output stays bound to that packet until its last phit has passed. Downstream buffer space is tracked per output and per virtual channel by credit counters. A phit sent takes one credit and an acknowledge pulse returns one. Competing inputs for one output are served in round-robin order.

Deadlock freedom inside each ring comes from a dateline. The wrap link between coordinate RADIX-1 and coordinate 0 is the designated link. A packet that crosses it moves to the upper virtual channel of its class and stays there for the rest of that dimension.

Top module: `torus_router`

## Requirements
- R1: Dimensions are resolved in the order X, Y, Z. A packet whose destination equals the node's own coordinates leaves on the local port 6. Output ports are numbered 2*dim+minus (0:+X, 1:-X, 2:+Y, 3:-Y, 4:+Z, 5:-Z).
- R2: Within a dimension, with p = (dst-cur) mod RADIX, the + direction is used when p <= RADIX-p and the - direction otherwise, so a tie goes to +.
- R3: The output virtual channel outVc is {class, level}. Class 0 is request and class 1 is response. The class of the header is carried through unchanged.
- R4: A packet entering a dimension it did not arrive in (including local injection) leaves at level 0, unless the hop it takes is itself the dateline link.
- R5: The dateline link is the wrap link (+ from RADIX-1, or - from 0). Taking it gives level 1. A packet continuing in the dimension it arrived in (input port p belongs to dimension p/2) keeps its incoming level.
- R6: Each output virtual channel starts with CRED_DEPTH credits, loses one per phit sent and gains one per ackIn pulse. A request is granted only when credits >= its length, and an exact match is enough.
- R7: Inputs contending for one output are arbitrated round-robin. After a grant to input i, the search for that output starts at i+1.
- R8: A granted output forwards each phit of its input one cycle after it arrives, for exactly reqLen phits. No other packet's phits interleave.
- R9: reqGrant is a one-cycle pulse, raised the cycle after a cycle in which reqValid was high. After reset, no grant and no output phit is present.
- R10: A packet ejected on the local port leaves at level 0 of its class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| myX | input | CW | Node X coordinate |
| myY | input | CW | Node Y coordinate |
| myZ | input | CW | Node Z coordinate |
| reqValid | input | 7 | Header request per input port |
| reqDstX | input | 7 x CW | Destination X per input |
| reqDstY | input | 7 x CW | Destination Y per input |
| reqDstZ | input | 7 x CW | Destination Z per input |
| reqClass | input | 7 | 0 request, 1 response |
| reqVc | input | 7 | Level the packet arrived on |
| reqLen | input | 7 x LEN_W | Packet length in phits |
| reqGrant | output | 7 | Grant pulse per input |
| inPhit | input | 7 x 16 | Phit data per input |
| inPhitValid | input | 7 | Phit present per input |
| outPhit | output | 7 x 16 | Phit data per output |
| outValid | output | 7 | Phit present per output |
| outVc | output | 7 x 2 | {class, level} of the phit |
| ackIn | input | 7 x 4 | Credit return per output and virtual channel |

## Verification
Two things can meet in one cycle: the last phit of a packet leaving an output, and a new request for that output or a credit return on the same channel. The bench sends two inputs at one output in the same cycle. It checks from the output stream that the packets do not interleave and that the second round's winner is not the previous last winner. A credit-starved request is held while acknowledges trickle in, and its grant must come exactly when the credits reach the packet length.

// File: rtl/torus_route_pkg.sv
package torus_route_pkg;
  localparam int NP = 7;
  localparam int NVC = 4;
  localparam int PW = 3;
  localparam int PHIT_W = 16;
  localparam int PORT_LOCAL = 6;

  typedef struct packed {
    logic          fwd;
    logic [PW-1:0] src;
    logic [1:0]    vc;
  } lane_t;
endpackage

// File: rtl/torus_route_dp.sv
module torus_route_dp
  import torus_route_pkg::*;
#(
  parameter int RADIX = 8,
  parameter int LEN_W = 5,
  parameter int CRED_DEPTH = 24,
  localparam int CW = $clog2(RADIX),
  localparam int CRW = $clog2(CRED_DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [CW-1:0]                 myX,
  input  logic [CW-1:0]                 myY,
  input  logic [CW-1:0]                 myZ,
  input  logic [NP-1:0]                 reqValid,
  input  logic [NP-1:0][CW-1:0]         reqDstX,
  input  logic [NP-1:0][CW-1:0]         reqDstY,
  input  logic [NP-1:0][CW-1:0]         reqDstZ,
  input  logic [NP-1:0]                 reqClass,
  input  logic [NP-1:0]                 reqVc,
  input  logic [NP-1:0][LEN_W-1:0]      reqLen,
  input  logic [NP-1:0][PHIT_W-1:0]     inPhit,
  input  logic [NP-1:0][NVC-1:0]        ackIn,
  input  lane_t [NP-1:0]                lane,
  output logic [NP-1:0][PW-1:0]         routePort,
  output logic [NP-1:0][1:0]            routeVc,
  output logic [NP-1:0]                 eligible,
  output logic [NP-1:0][PHIT_W-1:0]     outPhit,
  output logic [NP-1:0]                 outValid,
  output logic [NP-1:0][1:0]            outVc
);
  localparam logic [CRW-1:0] CRED_MAX = CRW'(CRED_DEPTH);

  logic [NP*NVC-1:0][CRW-1:0] creditFlat;

  // One ring hop decision: finished, direction, and whether the hop is the wrap link.
  function automatic void ringHop(input logic [CW-1:0] cur, input logic [CW-1:0] dst,
                                  output logic done, output logic goMinus,
                                  output logic wrap);
    int plusSteps;
    int minusSteps;
    plusSteps = (int'(dst) >= int'(cur)) ? int'(dst) - int'(cur)
                                         : int'(dst) + RADIX - int'(cur);
    minusSteps = RADIX - plusSteps;
    done = (plusSteps == 0);
    goMinus = (plusSteps > minusSteps);
    wrap = goMinus ? (int'(cur) == 0) : (int'(cur) == RADIX - 1);
  endfunction

  for (genvar gi = 0; gi < NP; gi++) begin : gRoute
    localparam logic [1:0] ARR_DIM = (gi == PORT_LOCAL) ? 2'd3 : 2'(gi / 2);
    logic [2:0] dn;
    logic [2:0] mn;
    logic [2:0] wr;
    logic [PW-1:0] port;
    logic lvl;
    int credIdx;

    always_comb begin
      ringHop(myX, reqDstX[gi], dn[0], mn[0], wr[0]);
      ringHop(myY, reqDstY[gi], dn[1], mn[1], wr[1]);
      ringHop(myZ, reqDstZ[gi], dn[2], mn[2], wr[2]);
      port = PW'(PORT_LOCAL);
      lvl = 1'b0;
      if (!dn[0]) begin
        port = {2'd0, mn[0]};
        lvl = wr[0] | ((ARR_DIM == 2'd0) & reqVc[gi]);
      end else if (!dn[1]) begin
        port = {2'd1, mn[1]};
        lvl = wr[1] | ((ARR_DIM == 2'd1) & reqVc[gi]);
      end else if (!dn[2]) begin
        port = {2'd2, mn[2]};
        lvl = wr[2] | ((ARR_DIM == 2'd2) & reqVc[gi]);
      end
    end

    assign routePort[gi] = port;
    assign routeVc[gi] = {reqClass[gi], lvl};
    assign credIdx = int'(port) * NVC + int'({reqClass[gi], lvl});
    assign eligible[gi] = reqValid[gi] && (reqLen[gi] != '0) &&
                          (int'(creditFlat[credIdx]) >= int'(reqLen[gi]));
  end

  for (genvar go = 0; go < NP; go++) begin : gOut
    for (genvar gv = 0; gv < NVC; gv++) begin : gCred
      logic [CRW-1:0] credCnt;
      logic takeOne;
      logic giveOne;
      assign takeOne = lane[go].fwd && (lane[go].vc == 2'(gv));
      assign giveOne = ackIn[go][gv];
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) credCnt <= CRED_MAX;
        else if (giveOne && !takeOne && credCnt != CRED_MAX) credCnt <= credCnt + 1'b1;
        else if (takeOne && !giveOne && credCnt != '0) credCnt <= credCnt - 1'b1;
      end
      assign creditFlat[go*NVC + gv] = credCnt;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outValid[go] <= 1'b0;
        outPhit[go] <= '0;
        outVc[go] <= '0;
      end else begin
        outValid[go] <= lane[go].fwd;
        if (lane[go].fwd) begin
          outPhit[go] <= inPhit[lane[go].src];
          outVc[go] <= lane[go].vc;
        end
      end
    end
  end
endmodule

// File: rtl/torus_route_ctrl.sv
module torus_route_ctrl
  import torus_route_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NP-1:0]            eligible,
  input  logic [NP-1:0][PW-1:0]    routePort,
  input  logic [NP-1:0][1:0]       routeVc,
  input  logic [NP-1:0][LEN_W-1:0] reqLen,
  input  logic [NP-1:0]            inPhitValid,
  output logic [NP-1:0]            reqGrant,
  output lane_t [NP-1:0]           lane
);
  logic [NP-1:0]          busy;
  logic [NP-1:0][PW-1:0]  srcSel;
  logic [NP-1:0]          take;
  logic [NP-1:0][PW-1:0]  pick;
  logic [NP-1:0]          inputBusy;
  logic [NP-1:0]          grantNext;

  always_comb begin
    inputBusy = '0;
    for (int o = 0; o < NP; o++)
      if (busy[o]) inputBusy[srcSel[o]] = 1'b1;
  end

  always_comb begin
    grantNext = '0;
    for (int o = 0; o < NP; o++)
      if (take[o]) grantNext[pick[o]] = 1'b1;
  end

  for (genvar go = 0; go < NP; go++) begin : gArb
    logic [NP-1:0] cand;
    logic [PW-1:0] lastQ;
    logic [PW-1:0] srcQ;
    logic [1:0] vcQ;
    logic [LEN_W-1:0] remQ;
    logic busyQ;
    logic found;
    logic [PW-1:0] sel;
    logic fwd;

    always_comb begin
      for (int i = 0; i < NP; i++)
        cand[i] = eligible[i] && !inputBusy[i] && (routePort[i] == PW'(go));
    end

    always_comb begin
      found = 1'b0;
      sel = '0;
      for (int k = 1; k <= NP; k++) begin
        int idx;
        idx = (int'(lastQ) + k) % NP;
        if (!found && cand[idx]) begin
          found = 1'b1;
          sel = PW'(idx);
        end
      end
    end

    assign fwd = busyQ && inPhitValid[srcQ];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        busyQ <= 1'b0;
        srcQ <= '0;
        vcQ <= '0;
        remQ <= '0;
        lastQ <= PW'(NP - 1);
      end else if (!busyQ) begin
        if (found) begin
          busyQ <= 1'b1;
          srcQ <= sel;
          vcQ <= routeVc[sel];
          remQ <= reqLen[sel];
          lastQ <= sel;
        end
      end else if (fwd) begin
        remQ <= remQ - 1'b1;
        if (remQ == LEN_W'(1)) busyQ <= 1'b0;
      end
    end

    assign busy[go] = busyQ;
    assign srcSel[go] = srcQ;
    assign take[go] = !busyQ && found;
    assign pick[go] = sel;
    assign lane[go] = '{fwd: fwd, src: srcQ, vc: vcQ};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqGrant <= '0;
    else reqGrant <= grantNext;
  end
endmodule

// File: rtl/torus_router.sv
module torus_router
  import torus_route_pkg::*;
#(
  parameter int RADIX = 8,
  parameter int LEN_W = 5,
  parameter int CRED_DEPTH = 24,
  localparam int CW = $clog2(RADIX)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [CW-1:0]                 myX,
  input  logic [CW-1:0]                 myY,
  input  logic [CW-1:0]                 myZ,
  input  logic [NP-1:0]                 reqValid,
  input  logic [NP-1:0][CW-1:0]         reqDstX,
  input  logic [NP-1:0][CW-1:0]         reqDstY,
  input  logic [NP-1:0][CW-1:0]         reqDstZ,
  input  logic [NP-1:0]                 reqClass,
  input  logic [NP-1:0]                 reqVc,
  input  logic [NP-1:0][LEN_W-1:0]      reqLen,
  output logic [NP-1:0]                 reqGrant,
  input  logic [NP-1:0][PHIT_W-1:0]     inPhit,
  input  logic [NP-1:0]                 inPhitValid,
  output logic [NP-1:0][PHIT_W-1:0]     outPhit,
  output logic [NP-1:0]                 outValid,
  output logic [NP-1:0][1:0]            outVc,
  input  logic [NP-1:0][NVC-1:0]        ackIn
);
  lane_t [NP-1:0]           lane;
  logic [NP-1:0][PW-1:0]    routePort;
  logic [NP-1:0][1:0]       routeVc;
  logic [NP-1:0]            eligible;

  torus_route_dp #(.RADIX(RADIX), .LEN_W(LEN_W), .CRED_DEPTH(CRED_DEPTH)) uDp (
    .clk(clk), .rstN(rstN), .myX(myX), .myY(myY), .myZ(myZ),
    .reqValid(reqValid), .reqDstX(reqDstX), .reqDstY(reqDstY), .reqDstZ(reqDstZ),
    .reqClass(reqClass), .reqVc(reqVc), .reqLen(reqLen), .inPhit(inPhit),
    .ackIn(ackIn), .lane(lane), .routePort(routePort), .routeVc(routeVc),
    .eligible(eligible), .outPhit(outPhit), .outValid(outValid), .outVc(outVc)
  );

  torus_route_ctrl #(.LEN_W(LEN_W)) uCtrl (
    .clk(clk), .rstN(rstN), .eligible(eligible), .routePort(routePort),
    .routeVc(routeVc), .reqLen(reqLen), .inPhitValid(inPhitValid),
    .reqGrant(reqGrant), .lane(lane)
  );
endmodule

// File: rtl/torus_router_checker.sv
module torus_router_checker
  import torus_route_pkg::*;
#(
  parameter int CRED_DEPTH = 24
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [NP-1:0]          reqValid,
  input logic [NP-1:0]          reqGrant,
  input logic [NP-1:0]          inPhitValid,
  input logic [NP-1:0]          outValid,
  input logic [NP-1:0][1:0]     outVc,
  input logic [NP-1:0][NVC-1:0] ackIn
);
  for (genvar gi = 0; gi < NP; gi++) begin : gPort
    AST_GRANT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
      reqGrant[gi] |-> $past(reqValid[gi])); // R9
    AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
      reqGrant[gi] |=> !reqGrant[gi]); // R9
    AST_OUT_FROM_IN: assert property (@(posedge clk) disable iff (!rstN)
      outValid[gi] |-> $past(|inPhitValid)); // R8

    for (genvar gv = 0; gv < NVC; gv++) begin : gVc
      int pending;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pending <= 0;
        else pending <= pending + ((outValid[gi] && outVc[gi] == 2'(gv)) ? 1 : 0)
                                - ((ackIn[gi][gv] && pending > 0) ? 1 : 0);
      end
      AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
        pending <= CRED_DEPTH); // R6
    end
  end

  AST_EJECT_LEVEL0: assert property (@(posedge clk) disable iff (!rstN)
    outValid[PORT_LOCAL] |-> !outVc[PORT_LOCAL][0]); // R10
endmodule

bind torus_router torus_router_checker #(.CRED_DEPTH(CRED_DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqGrant(reqGrant),
  .inPhitValid(inPhitValid), .outValid(outValid), .outVc(outVc), .ackIn(ackIn)
);

// File: tb/torus_router_test.sv
`timescale 1ns/1ps
module torus_router_test;
  import torus_route_pkg::*;
  localparam int K = 8;
  localparam int CW = 3;
  localparam int LW = 5;
  localparam int CD = 24;
  localparam int MX = 7, MY = 0, MZ = 3;

  logic clk = 0;
  logic rstN = 0;
  logic [NP-1:0] reqValid = '0;
  logic [NP-1:0][CW-1:0] reqDstX = '0, reqDstY = '0, reqDstZ = '0;
  logic [NP-1:0] reqClass = '0, reqVc = '0;
  logic [NP-1:0][LW-1:0] reqLen = '0;
  logic [NP-1:0] reqGrant;
  logic [NP-1:0][PHIT_W-1:0] inPhit = '0;
  logic [NP-1:0] inPhitValid = '0;
  logic [NP-1:0][PHIT_W-1:0] outPhit;
  logic [NP-1:0] outValid;
  logic [NP-1:0][1:0] outVc;
  logic [NP-1:0][NVC-1:0] ackIn = '0;

  int nTests = 0, nFail = 0;
  bit finished = 0;
  int seq = 0;
  logic [15:0] obsData [NP][64];
  logic [1:0]  obsVc [NP][64];
  int obsCnt [NP];

  always #4 clk = ~clk;

  torus_router #(.RADIX(K), .LEN_W(LW), .CRED_DEPTH(CD)) uut (
    .clk(clk), .rstN(rstN), .myX(CW'(MX)), .myY(CW'(MY)), .myZ(CW'(MZ)),
    .reqValid(reqValid), .reqDstX(reqDstX), .reqDstY(reqDstY), .reqDstZ(reqDstZ),
    .reqClass(reqClass), .reqVc(reqVc), .reqLen(reqLen), .reqGrant(reqGrant),
    .inPhit(inPhit), .inPhitValid(inPhitValid), .outPhit(outPhit),
    .outValid(outValid), .outVc(outVc), .ackIn(ackIn)
  );

  always @(negedge clk) begin
    for (int o = 0; o < NP; o++)
      if (outValid[o] && obsCnt[o] < 64) begin
        obsData[o][obsCnt[o]] = outPhit[o];
        obsVc[o][obsCnt[o]] = outVc[o];
        obsCnt[o]++;
      end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clearObs();
    for (int o = 0; o < NP; o++) obsCnt[o] = 0;
  endtask

  // Reference route: returns port and {class, level}.
  function automatic void model(input int inPort, input int dx, input int dy, input int dz,
                                input int cls, input int vcIn, output int port, output int vc);
    int cur[3];
    int dst[3];
    int lvl;
    cur[0] = MX; cur[1] = MY; cur[2] = MZ;
    dst[0] = dx; dst[1] = dy; dst[2] = dz;
    port = PORT_LOCAL;
    lvl = 0;
    for (int d = 2; d >= 0; d--) begin
      int fwdDist;
      fwdDist = (dst[d] - cur[d] + K) % K;
      if (fwdDist != 0) begin
        bit minus;
        bit wrap;
        minus = (K - fwdDist) < fwdDist;
        wrap = minus ? (cur[d] == 0) : (cur[d] == K - 1);
        port = 2 * d + (minus ? 1 : 0);
        lvl = (wrap || (inPort != PORT_LOCAL && inPort / 2 == d && vcIn == 1)) ? 1 : 0;
      end
    end
    vc = cls * 2 + lvl;
  endfunction

  task automatic startReq(input int p, input int dx, input int dy, input int dz,
                          input int cls, input int vcIn, input int len);
    reqValid[p] = 1'b1;
    reqDstX[p] = CW'(dx); reqDstY[p] = CW'(dy); reqDstZ[p] = CW'(dz);
    reqClass[p] = cls[0]; reqVc[p] = vcIn[0]; reqLen[p] = LW'(len);
  endtask

  task automatic waitGrant(input int p, input int limit, output bit ok);
    int n;
    n = 0;
    ok = 0;
    while (!ok && n < limit) begin
      @(negedge clk);
      if (reqGrant[p]) ok = 1;
      n++;
    end
  endtask

  task automatic streamPhits(input int p, input int len);
    for (int k = 0; k < len; k++) begin
      inPhit[p] = {4'(p), 12'(seq)};
      seq++;
      inPhitValid[p] = 1'b1;
      @(negedge clk);
    end
    inPhitValid[p] = 1'b0;
  endtask

  task automatic sendPkt(input int p, input int dx, input int dy, input int dz,
                         input int cls, input int vcIn, input int len, output bit ok);
    @(negedge clk);
    startReq(p, dx, dy, dz, cls, vcIn, len);
    waitGrant(p, 60, ok);
    reqValid[p] = 1'b0;
    if (ok) streamPhits(p, len);
  endtask

  task automatic ackCredits(input int o, input int v, input int n);
    repeat (n) begin
      @(negedge clk);
      ackIn[o][v] = 1'b1;
    end
    @(negedge clk);
    ackIn[o][v] = 1'b0;
  endtask

  // Send one packet, verify route, VC and phit stream, then return its credits.
  task automatic routeCase(input string req, input int p, input int dx, input int dy,
                           input int dz, input int cls, input int vcIn, input int len);
    int ep, ev;
    bit ok;
    int firstSeq;
    model(p, dx, dy, dz, cls, vcIn, ep, ev);
    clearObs();
    firstSeq = seq;
    sendPkt(p, dx, dy, dz, cls, vcIn, len, ok);
    repeat (2) @(negedge clk);
    check(ok, req, "grant seen", int'(ok), 1);
    check(obsCnt[ep] == len, req, "phits on expected port", obsCnt[ep], len);
    for (int o = 0; o < NP; o++)
      if (o != ep) check(obsCnt[o] == 0, req, "stray phits", obsCnt[o], 0);
    if (obsCnt[ep] > 0) begin
      check(int'(obsVc[ep][0]) == ev, req, "vc", int'(obsVc[ep][0]), ev);
      for (int k = 0; k < len && k < obsCnt[ep]; k++)
        check(obsData[ep][k] == {4'(p), 12'(firstSeq + k)}, "R8", "phit order",
              int'(obsData[ep][k]), int'({4'(p), 12'(firstSeq + k)}));
    end
    ackCredits(ep, ev, len);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    bit ok;
    bit seenGrant;
    int winA, winB, win2;
    bit contig;
    void'($urandom(32'd4711));
    clearObs();
    repeat (3) @(negedge clk);
    check(outValid == '0, "R9", "outValid in reset", int'(outValid), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(reqGrant == '0, "R9", "grant after reset", int'(reqGrant), 0);
    check(outValid == '0, "R9", "outValid after reset", int'(outValid), 0);

    // Directed routing corners
    routeCase("R2", 6, 3, 0, 3, 0, 0, 3);   // tie in X goes +, wrap from 7 -> level 1
    routeCase("R5", 1, 5, 0, 3, 0, 1, 2);   // continuing -X keeps level 1
    routeCase("R5", 1, 5, 0, 3, 1, 0, 2);   // continuing -X keeps level 0
    routeCase("R4", 0, 7, 2, 3, 0, 1, 2);   // new dim Y resets to level 0
    routeCase("R5", 6, 7, 6, 3, 1, 0, 2);   // -Y from 0 is dateline -> level 1
    routeCase("R10", 4, 7, 0, 3, 1, 1, 2);  // ejection, level 0, class kept
    routeCase("R1", 6, 5, 4, 0, 0, 0, 2);   // X before Y and Z
    routeCase("R1", 6, 7, 0, 1, 1, 0, 2);   // only Z left -> -Z
    routeCase("R3", 2, 7, 3, 3, 1, 0, 3);   // response class on +Y

    // Random traffic
    for (int t = 0; t < 40; t++) begin
      int p;
      p = int'($urandom % NP);
      routeCase("R3", p, int'($urandom % K), int'($urandom % K), int'($urandom % K),
                int'($urandom % 2), int'($urandom % 2), 1 + int'($urandom % 6));
    end

    // Credit starvation on +Z response level 0 (vc 2)
    clearObs();
    sendPkt(6, 7, 0, 4, 1, 0, 16, ok);
    check(ok, "R6", "first packet granted", int'(ok), 1);
    @(negedge clk);
    startReq(6, 7, 0, 4, 1, 0, 10);
    waitGrant(6, 20, seenGrant);
    check(!seenGrant, "R6", "grant without credits", int'(seenGrant), 0);
    fork
      ackCredits(4, 2, 2);
      waitGrant(6, 20, seenGrant);
    join
    reqValid[6] = 1'b0;
    check(seenGrant, "R6", "grant once credits match", int'(seenGrant), 1);
    if (seenGrant) streamPhits(6, 10);
    repeat (2) @(negedge clk);
    check(obsCnt[4] == 26, "R6", "phits after starvation", obsCnt[4], 26);
    ackCredits(4, 2, 8);
    sendPkt(6, 7, 0, 4, 1, 0, 8, ok);
    check(ok, "R6", "exact credit grant", int'(ok), 1);
    ackCredits(4, 2, 24);

    // Round-robin between inputs 0 and 6 on +X
    for (int round = 0; round < 2; round++) begin
      bit okA, okB;
      clearObs();
      fork
        sendPkt(0, 2, 0, 3, 0, 0, 4, okA);
        sendPkt(6, 2, 0, 3, 0, 0, 4, okB);
      join
      repeat (2) @(negedge clk);
      check(obsCnt[0] == 8, "R7", "both packets delivered", obsCnt[0], 8);
      contig = 1;
      for (int k = 1; k < 8; k++)
        if ((k != 4) && (obsData[0][k][15:12] != obsData[0][k-1][15:12])) contig = 0;
      check(contig, "R8", "no interleave", int'(contig), 1);
      if (round == 0) begin
        winA = int'(obsData[0][0][15:12]);
        winB = int'(obsData[0][4][15:12]);
        check(winA != winB, "R7", "two distinct winners", winB, 6 - winA);
      end else begin
        win2 = int'(obsData[0][0][15:12]);
        check(win2 != winB, "R7", "rotation after last grant", win2, winA);
      end
      ackCredits(0, 1, 8);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule